// File: doc/BRIEF.md
# Two-wire memory slave

This block is the bus-side front end of a 4096-byte serial memory. It watches an oversampled serial clock and data pair, recognises START and STOP conditions, and decodes the byte stream that follows. The first byte selects the device and the direction. On a write, two address bytes follow, and after them any number of data bytes. On a read, bytes stream back from the current address. The block acknowledges each accepted byte by pulling the data line low through an open-drain enable.

On the memory side it issues one-cycle write strobes carrying an address and a data byte. It also issues one-cycle read strobes and expects the addressed byte on the following clock. A busy input from the programming logic suppresses every acknowledge, so a master that polls the block sees it ignore the bus until programming ends. A START followed by a read control byte, with no address phase, reads from the address left by the last access. A write that stops after its address bytes therefore sets up a random read.

Top module: `twm_slave`

## Requirements
- R1: A falling data edge while the clock is high (START) restarts control-byte decoding from any state. A rising data edge while the clock is high (STOP) returns the block to idle with the data line released.
- R2: A control byte whose bits 7..4 are 1010 and whose bits 3..1 equal `sel_i` is acknowledged: `sda_oe_o` is high through the ninth clock's high period. Bit 0 gives the direction, with 1 for read and 0 for write.
- R3: A control byte with a wrong type code or wrong select bits is not acknowledged. All later bytes are then ignored until the next START: no acknowledge and no memory write.
- R4: On a write, the two bytes after the control byte form the address, high byte first. A high address byte with any of bits 7..4 set is not acknowledged, and the rest of the transfer causes no write.
- R5: Each acknowledged write data byte produces exactly one one-cycle `mem_wr_o` pulse carrying the current address and the byte. The address then advances by one.
- R6: While `busy_i` is high, no byte is acknowledged and no write is issued, including in the middle of a transfer.
- R7: A read control byte fetches the byte at the current address and shifts it out MSB first. `sda_oe_o` is high exactly for the zero bits, and the line is released for the master's acknowledge clock.
- R8: During a read, a master acknowledge (data low on the ninth clock) makes the block send the next address's byte. A missing acknowledge ends the read and leaves the data line released.
- R9: The address counter wraps from 4095 to 0 on both reads and writes.
- R10: A write carrying only an address, followed by a repeated START and a read control byte, reads from that address.
- R11: `mem_rdata_i` is taken on the cycle after `mem_rd_o`. `mem_rd_o` and `mem_wr_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 3 | Strapped device select value |
| busy_i | input | 1 | Programming cycle in progress |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe_o | output | 1 | Pull data line low when high |
| mem_wr_o | output | 1 | One-cycle byte write strobe |
| mem_rd_o | output | 1 | One-cycle byte read strobe |
| mem_addr_o | output | 12 | Byte address for the memory |
| mem_wdata_o | output | 8 | Byte to be written |
| mem_rdata_i | input | 8 | Byte read, valid one cycle after the strobe |

## Verification
Control bytes are tried with the correct value, with a wrong select field and with a wrong type code, which separates the type match from the select match. Address bytes are sent with a clean and with a dirty upper nibble, and busy is raised both before a transfer and between two address bytes, so that an acknowledge gate which looks only at the first byte is caught. Reads run across the 4095-to-0 boundary through master acknowledges and end with a missing acknowledge. A following current-address read confirms where the counter stopped, and a repeated START in the middle of a write shows that decoding restarts.

// File: rtl/twm_pkg.sv
package twm_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_CTRL,
      S_AHI,
      S_ALO,
      S_WDAT,
      S_RDAT
   } twm_state_e;

   localparam logic [3:0] TWM_TYPE_CODE = 4'b1010;

endpackage

// File: rtl/twm_sync.sv
module twm_sync #(
   parameter int             WIDTH   = 2,
   parameter int             STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("twm_sync needs at least two stages");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d_i};
   end

   assign q_o = chain[STAGES-1];

endmodule

// File: rtl/twm_addr_ctr.sv
module twm_addr_ctr #(
   parameter int AW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [AW-1:0] load_val_i,
   input  logic          inc_i,
   output logic [AW-1:0] addr_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_o <= '0;
      else if (load_i) addr_o <= load_val_i;
      else if (inc_i)  addr_o <= addr_o + 1'b1;
   end

   // R9: a step past the top of the space lands on zero
   assert_addr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      inc_i && !load_i |=> addr_o == $past(addr_o) + 1'b1);

endmodule

// File: rtl/twm_slave.sv
module twm_slave
   import twm_pkg::*;
#(
   parameter int         ADDR_W      = 12,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] DEV_TYPE    = TWM_TYPE_CODE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        sel_i,
   input  logic              busy_i,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   output logic              mem_wr_o,
   output logic              mem_rd_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [7:0]        mem_wdata_o,
   input  logic [7:0]        mem_rdata_i
);

   localparam int HI_W = ADDR_W - 8;

   if (ADDR_W < 9 || ADDR_W > 15) begin : g_bad_aw
      $error("twm_slave ADDR_W must lie in 9..15");
   end

   // line synchronisation and bus condition detection
   logic [1:0] bus_s;
   logic       scl_s, sda_s, scl_q, sda_q;
   logic       scl_rise, scl_fall, start_det, stop_det;

   twm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  ({scl_i, sda_i}),
      .q_o  (bus_s)
   );

   assign scl_s = bus_s[1];
   assign sda_s = bus_s[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

   // byte sequencer state
   twm_state_e      state;
   logic [3:0]      bit_cnt;
   logic [7:0]      rx_sh, tx_sh;
   logic            ack_ph, mack_ph, next_read, rd_d, op_d, addr_ld;
   logic [HI_W-1:0] hi_q;
   logic            byte_ok;

   always_comb begin
      unique case (state)
         S_CTRL:         byte_ok = (rx_sh[7:4] == DEV_TYPE) && (rx_sh[3:1] == sel_i);
         S_AHI:          byte_ok = (rx_sh[7:HI_W] == '0);
         S_ALO, S_WDAT:  byte_ok = 1'b1;
         default:        byte_ok = 1'b0;
      endcase
      byte_ok = byte_ok & ~busy_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= S_IDLE;
         bit_cnt     <= '0;
         rx_sh       <= '0;
         tx_sh       <= '0;
         ack_ph      <= 1'b0;
         mack_ph     <= 1'b0;
         next_read   <= 1'b0;
         hi_q        <= '0;
         sda_oe_o    <= 1'b0;
         mem_wr_o    <= 1'b0;
         mem_rd_o    <= 1'b0;
         mem_wdata_o <= '0;
         rd_d        <= 1'b0;
         op_d        <= 1'b0;
         addr_ld     <= 1'b0;
      end else begin
         mem_wr_o <= 1'b0;
         mem_rd_o <= 1'b0;
         addr_ld  <= 1'b0;
         rd_d     <= mem_rd_o;
         op_d     <= mem_rd_o | mem_wr_o;
         if (rd_d) tx_sh <= mem_rdata_i;

         if (start_det || stop_det) begin
            state     <= start_det ? S_CTRL : S_IDLE;
            bit_cnt   <= '0;
            ack_ph    <= 1'b0;
            mack_ph   <= 1'b0;
            next_read <= 1'b0;
            sda_oe_o  <= 1'b0;
         end else if (state == S_RDAT) begin
            if (scl_rise) begin
               if (mack_ph) begin
                  if (sda_s) state    <= S_IDLE;
                  else       mem_rd_o <= 1'b1;
               end else begin
                  bit_cnt <= bit_cnt + 4'd1;
               end
            end else if (scl_fall) begin
               if (mack_ph) begin
                  mack_ph  <= 1'b0;
                  bit_cnt  <= '0;
                  sda_oe_o <= ~tx_sh[7];
               end else if (bit_cnt == 4'd8) begin
                  sda_oe_o <= 1'b0;
                  mack_ph  <= 1'b1;
               end else begin
                  tx_sh    <= {tx_sh[6:0], 1'b0};
                  sda_oe_o <= ~tx_sh[6];
               end
            end
         end else if (state != S_IDLE) begin
            if (scl_rise && !ack_ph) begin
               rx_sh   <= {rx_sh[6:0], sda_s};
               bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall) begin
               if (ack_ph) begin
                  ack_ph  <= 1'b0;
                  bit_cnt <= '0;
                  if (next_read) begin
                     state    <= S_RDAT;
                     sda_oe_o <= ~tx_sh[7];
                  end else begin
                     sda_oe_o <= 1'b0;
                  end
               end else if (bit_cnt == 4'd8) begin
                  if (byte_ok) begin
                     ack_ph   <= 1'b1;
                     sda_oe_o <= 1'b1;
                     unique case (state)
                        S_CTRL: begin
                           if (rx_sh[0]) begin
                              next_read <= 1'b1;
                              mem_rd_o  <= 1'b1;
                           end else begin
                              state <= S_AHI;
                           end
                        end
                        S_AHI: begin
                           hi_q  <= rx_sh[HI_W-1:0];
                           state <= S_ALO;
                        end
                        S_ALO: begin
                           addr_ld <= 1'b1;
                           state   <= S_WDAT;
                        end
                        default: begin
                           mem_wr_o    <= 1'b1;
                           mem_wdata_o <= rx_sh;
                        end
                     endcase
                  end else begin
                     state <= S_IDLE;
                  end
               end
            end
         end
      end
   end

   twm_addr_ctr #(.AW(ADDR_W)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (addr_ld),
      .load_val_i({hi_q, rx_sh}),
      .inc_i     (op_d),
      .addr_o    (mem_addr_o)
   );

   // R6: an acknowledge only starts when busy was low at the decision
   assert_no_ack_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_ph) |-> $past(!busy_i));

   // R1: a STOP leaves the data line released
   assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe_o);

   // R11: never a read and a write strobe in the same cycle
   assert_ops_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_wr_o && mem_rd_o));

   // R5: each write strobe lasts one cycle
   assert_wr_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_o |=> !mem_wr_o);

   // R8: while waiting for the master acknowledge the line is free
   assert_mack_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mack_ph && scl_rise |-> !sda_oe_o);

endmodule

// File: tb/tb_twm_slave.sv
module tb_twm_slave;

   localparam int         CLK_PERIOD = 10;
   localparam int         Q          = 8;
   localparam logic [2:0] SEL        = 3'b101;
   localparam logic [7:0] CW         = {4'b1010, SEL, 1'b0};
   localparam logic [7:0] CR         = {4'b1010, SEL, 1'b1};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic        scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
   logic        sda_oe, mem_wr, mem_rd;
   logic [11:0] mem_addr;
   logic [7:0]  mem_wdata, mem_rdata;
   logic        sda_line;
   assign sda_line = sda_m & ~sda_oe;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   typedef struct packed { logic [11:0] a; logic [7:0] d; } wr_t;
   wr_t exp_q[$];

   twm_slave dut (
      .clk(clk), .rst_n(rst_n), .sel_i(SEL), .busy_i(busy),
      .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
      .mem_wr_o(mem_wr), .mem_rd_o(mem_rd), .mem_addr_o(mem_addr),
      .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
   );

   function automatic logic [7:0] model(input logic [11:0] a);
      return a[7:0] + {a[11:8], 4'h3};
   endfunction

   always @(posedge clk) if (mem_rd) mem_rdata <= model(mem_addr);

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // scoreboard monitor for memory writes (R5)
   always @(negedge clk) begin
      if (rst_n && mem_wr) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R5 unexpected write", {12'h0, mem_addr, mem_wdata}, 32'h0);
         end else begin
            wr_t e;
            e = exp_q.pop_front();
            chk({mem_addr, mem_wdata} == e, "R5 write addr/data", {12'h0, mem_addr, mem_wdata}, {12'h0, e});
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
      sda_m = 1'b1; tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
      end
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
      acked = ~sda_line;
      tick(Q); scl_m = 1'b0; tick(Q);
   endtask

   task automatic recv_byte(input bit give_ack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         tick(Q); scl_m = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl_m = 1'b0;
      end
      tick(Q); sda_m = give_ack ? 1'b0 : 1'b1;
      tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
      sda_m = 1'b1;
   endtask

   initial begin
      repeat (100000) @(negedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      bit a;
      logic [7:0] rb;
      tick(5);
      rst_n = 1'b1;
      tick(3);
      chk(!sda_oe && !mem_wr && !mem_rd, "R1 reset state", {sda_oe, mem_wr, mem_rd}, 0);

      // plain write of three bytes at 0x123
      bus_start();
      send_byte(CW, a);    chk(a, "R2 control ack", a, 1);
      send_byte(8'h01, a); chk(a, "R4 address high ack", a, 1);
      send_byte(8'h23, a); chk(a, "R4 address low ack", a, 1);
      exp_q.push_back({12'h123, 8'h11}); send_byte(8'h11, a); chk(a, "R5 data ack", a, 1);
      exp_q.push_back({12'h124, 8'h22}); send_byte(8'h22, a);
      exp_q.push_back({12'h125, 8'h33}); send_byte(8'h33, a);
      bus_stop(); tick(2);
      chk(!sda_oe, "R1 released after stop", sda_oe, 0);

      // wrong select, then wrong type code
      bus_start();
      send_byte({4'b1010, 3'b011, 1'b0}, a); chk(!a, "R3 wrong select nack", a, 0);
      send_byte(8'h55, a);                   chk(!a, "R3 later byte ignored", a, 0);
      bus_stop();
      bus_start();
      send_byte({4'b1011, SEL, 1'b0}, a);    chk(!a, "R3 wrong type nack", a, 0);
      bus_stop();

      // dirty upper address nibble
      bus_start();
      send_byte(CW, a);
      send_byte(8'h10, a); chk(!a, "R4 upper nibble nack", a, 0);
      send_byte(8'h00, a); chk(!a, "R4 rest ignored", a, 0);
      bus_stop();

      // busy before and during a transfer
      busy = 1'b1;
      bus_start();
      send_byte(CW, a); chk(!a, "R6 busy control nack", a, 0);
      bus_stop();
      busy = 1'b0;
      bus_start();
      send_byte(CW, a);
      send_byte(8'h00, a); chk(a, "R6 ack before busy", a, 1);
      busy = 1'b1;
      send_byte(8'h40, a); chk(!a, "R6 busy mid nack", a, 0);
      send_byte(8'h99, a); chk(!a, "R6 no write while busy", a, 0);
      busy = 1'b0;
      bus_stop();

      // random read across the top of the space
      bus_start();
      send_byte(CW, a);
      send_byte(8'h0F, a);
      send_byte(8'hFE, a);
      bus_start();
      send_byte(CR, a); chk(a, "R10 read control ack", a, 1);
      recv_byte(1'b1, rb); chk(rb == model(12'hFFE), "R10 random read byte", rb, model(12'hFFE));
      recv_byte(1'b1, rb); chk(rb == model(12'hFFF), "R8 sequential byte", rb, model(12'hFFF));
      recv_byte(1'b0, rb); chk(rb == model(12'h000), "R9 wrap to zero", rb, model(12'h000));
      tick(2);
      chk(!sda_oe, "R8 released after master nack", sda_oe, 0);
      bus_stop();

      // current-address read
      bus_start();
      send_byte(CR, a);
      recv_byte(1'b0, rb); chk(rb == model(12'h001), "R7 current address read", rb, model(12'h001));
      bus_stop();

      // repeated START in the middle of a write restarts decoding
      bus_start();
      send_byte(CW, a);
      send_byte(8'h00, a);
      bus_start();
      send_byte(CW, a); chk(a, "R1 restart control ack", a, 1);
      send_byte(8'h00, a);
      send_byte(8'h02, a);
      exp_q.push_back({12'h002, 8'h44}); send_byte(8'h44, a); chk(a, "R1 write after restart", a, 1);
      bus_stop();

      // write wrap from the top address
      bus_start();
      send_byte(CW, a);
      send_byte(8'h0F, a);
      send_byte(8'hFF, a);
      exp_q.push_back({12'hFFF, 8'hA5}); send_byte(8'hA5, a);
      exp_q.push_back({12'h000, 8'h5A}); send_byte(8'h5A, a);
      bus_stop();

      tick(10);
      chk(exp_q.size() == 0, "R5 all expected writes seen", exp_q.size(), 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule